// File: doc/BRIEF.md
# Periodic Compare Interrupt Timer

This block is a 32-bit down-counting timer that sits on a simple word-addressed register bus. Software picks one of three tick enables as the count clock (or none, which freezes the count), sets a 12-bit division factor, and chooses between reloading the counter from a load value at zero or letting it wrap to all ones. When the counter steps onto the value held in the compare register, a sticky status flag is raised. The flag drives a level interrupt when the interrupt and timer enables are both set.

Software can clear the flag by writing a one to it. It can restart the count when the timer is enabled, and it can force the counter the moment the load register is written. A self-clearing reset bit in the control register returns the block to a known state while keeping the mode bits. The low-power and debug stop bits are stored but have no effect.

Top module: `cmptmr_top`

## Requirements
- R1: Word index 0 is control, 1 status, 2 load, 3 compare, 4 counter. The counter register is read-only. Reads of indices 5 to 7 return 0, and writes to indices 4 to 7 change nothing.
- R2: The control bits 25:24 select the count tick: 00 none (the counter is frozen), 01 `tick_main`, 10 `tick_fast`, 11 `tick_slow`.
- R3: The counter steps once for every (prescale + 1) selected ticks, where prescale is control bits 15:4.
- R4: `irq` is high exactly when the status flag (status bit 0), interrupt enable (control bit 2) and timer enable (control bit 0) are all set.
- R5: Writing status bit 0 as 1 clears the flag. Writing it as 0 leaves the flag unchanged.
- R6: A control write stores only bits 25:0. Bits 31:26 read back as 0.
- R7: A control write with bit 16 set keeps only bits 0, 1, 18, 19, 20 and 21 of the written value, and bit 16 reads back as 0. It also clears the status, sets load to 0xFFFFFFFF and compare to 0, and leaves the counter frozen.
- R8: After hardware reset: control 0, status 0, load 0xFFFFFFFF, compare 0, counter 0xFFFFFFFF, `irq` low.
- R9: A step from 0 goes to the load value when reload (control bit 3) is set, and to 0xFFFFFFFF when it is clear. Any other step decrements the counter by one.
- R10: A control write that takes enable from 0 to 1 with enable-mode (bit 1) set loads the counter. It loads the load value if the written reload bit is set, and 0xFFFFFFFF if it is clear.
- R11: A load-register write while overwrite-enable (control bit 17) is set also puts the written value into the counter at once.
- R12: A step onto the compare value sets the flag, whether or not the interrupt is enabled. With reload set, a compare value above the load value is never reached.
- R13: The counter does not step while control bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_main | input | 1 | Count tick enable, source 01 |
| tick_fast | input | 1 | Count tick enable, source 10 |
| tick_slow | input | 1 | Count tick enable, source 11 |
| irq | output | 1 | Level compare interrupt |

## Verification
A register write takes effect on the clock edge that samples the strobe. Read data follows the address combinationally. A counted tick moves the counter, and sets the flag and `irq`, on the edge that samples the tick. So every result is due one edge after its stimulus. The bench drives writes and ticks just after a rising edge and never overlaps them. It queues each expected value and has the monitor compare it at the following falling edge, after at least one whole edge has passed. This means prescaler phase and tick counts are known exactly at every check.

// File: rtl/cmptmr_pkg.sv
package cmptmr_pkg;
  localparam int DW       = 32;
  localparam int ADDR_W   = 3;
  localparam int SRC_W    = 2;
  localparam int NSRC     = 3;
  localparam int PSC_W    = 12;

  // control bit positions
  localparam int B_EN     = 0;
  localparam int B_ENMOD  = 1;
  localparam int B_IE     = 2;
  localparam int B_RLD    = 3;
  localparam int B_PSC    = 4;
  localparam int B_SWR    = 16;
  localparam int B_OVW    = 17;
  localparam int B_DBG    = 18;
  localparam int B_WAIT   = 19;
  localparam int B_DOZE   = 20;
  localparam int B_STOP   = 21;
  localparam int B_SRC    = 24;

  // register word indices
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_LOAD = 2;
  localparam int IDX_CMP  = 3;
  localparam int IDX_CNT  = 4;

  localparam logic [DW-1:0] CTRL_MASK = DW'((1 << (B_SRC + SRC_W)) - 1);
  localparam logic [DW-1:0] SWR_KEEP  = (DW'(1) << B_EN)   | (DW'(1) << B_ENMOD) |
                                        (DW'(1) << B_DBG)  | (DW'(1) << B_WAIT)  |
                                        (DW'(1) << B_DOZE) | (DW'(1) << B_STOP);
endpackage

// File: rtl/cmptmr_prescale.sv
module cmptmr_prescale #(
  parameter int PSC_W = 12,
  parameter int SRC_W = 2,
  parameter int NSRC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SRC_W-1:0] src,
  input  logic [NSRC-1:0]  ticks,
  input  logic [PSC_W-1:0] presc,
  input  logic             clr,
  output logic             step
);
  logic [PSC_W-1:0] psc_q, psc_d;
  logic             sel_tick;
  logic             run;

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src == SRC_W'(i + 1)) sel_tick = ticks[i];
    end
  end

  assign run  = enable && (src != '0) && !clr;
  assign step = run && sel_tick && (psc_q >= presc);

  always_comb begin
    psc_d = psc_q;
    if (!run)             psc_d = '0;
    else if (sel_tick) begin
      if (psc_q >= presc) psc_d = '0;
      else                psc_d = psc_q + PSC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // R3: after a divided step the phase restarts from zero
  p_phase_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (psc_q == '0));
endmodule

// File: rtl/cmptmr_count.sv
module cmptmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             rld,
  input  logic [CNT_W-1:0] lim,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONES = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, stepped;

  assign stepped = (cnt_q == '0) ? (rld ? lim : ONES) : cnt_q - CNT_W'(1);
  assign hit     = step && !load && (stepped == cmp);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ONES;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R13 / R2: no step and no load keeps the count
  p_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt_q));
  // R9: wrap to all ones without reload
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q == '0 && !rld) |=> (cnt_q == ONES));
  // R9: reload from the limit
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q == '0 && rld) |=> (cnt_q == $past(lim)));
  // R9: plain decrement
  p_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/cmptmr_top.sv
module cmptmr_top
  import cmptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tick_main,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  localparam logic [DW-1:0] ONES = '1;

  logic [DW-1:0] cr_q, cr_d, lr_q, lr_d, cmp_q, cmp_d, cnt, load_val;
  logic          flag_q, flag_d;
  logic          wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic          load, sw_rst, step, hit;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(IDX_CTRL));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(IDX_STAT));
  assign wr_load = bus_wr && (bus_addr == ADDR_W'(IDX_LOAD));
  assign wr_cmp  = bus_wr && (bus_addr == ADDR_W'(IDX_CMP));

  always_comb begin
    cr_d     = cr_q;
    lr_d     = lr_q;
    cmp_d    = cmp_q;
    flag_d   = flag_q || hit;
    sw_rst   = 1'b0;
    load     = 1'b0;
    load_val = lr_q;
    if (wr_stat && bus_wdata[0]) flag_d = hit;
    if (wr_load) begin
      lr_d = bus_wdata;
      if (cr_q[B_OVW]) begin
        load     = 1'b1;
        load_val = bus_wdata;
      end
    end
    if (wr_cmp) cmp_d = bus_wdata;
    if (wr_ctrl) begin
      if (bus_wdata[B_SWR]) begin
        cr_d   = bus_wdata & SWR_KEEP;
        flag_d = 1'b0;
        lr_d   = ONES;
        cmp_d  = '0;
        sw_rst = 1'b1;
      end else begin
        cr_d = bus_wdata & CTRL_MASK;
        if (!cr_q[B_EN] && bus_wdata[B_EN] && bus_wdata[B_ENMOD]) begin
          load     = 1'b1;
          load_val = bus_wdata[B_RLD] ? lr_q : ONES;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q   <= '0;
      lr_q   <= ONES;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cr_q   <= cr_d;
      lr_q   <= lr_d;
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
    end
  end

  cmptmr_prescale #(.PSC_W(PSC_W), .SRC_W(SRC_W), .NSRC(NSRC)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (cr_q[B_EN]),
    .src    (cr_q[B_SRC +: SRC_W]),
    .ticks  ({tick_slow, tick_fast, tick_main}),
    .presc  (cr_q[B_PSC +: PSC_W]),
    .clr    (sw_rst),
    .step   (step)
  );

  cmptmr_count #(.CNT_W(DW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (load),
    .load_val (load_val),
    .rld      (cr_q[B_RLD]),
    .lim      (lr_q),
    .cmp      (cmp_q),
    .cnt      (cnt),
    .hit      (hit)
  );

  always_comb begin
    case (bus_addr)
      ADDR_W'(IDX_CTRL): bus_rdata = cr_q;
      ADDR_W'(IDX_STAT): bus_rdata = {{(DW-1){1'b0}}, flag_q};
      ADDR_W'(IDX_LOAD): bus_rdata = lr_q;
      ADDR_W'(IDX_CMP):  bus_rdata = cmp_q;
      ADDR_W'(IDX_CNT):  bus_rdata = cnt;
      default:           bus_rdata = '0;
    endcase
  end

  assign irq = flag_q && cr_q[B_IE] && cr_q[B_EN];

  // R7: soft reset restores load, compare, status and self-clears
  p_softrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[B_SWR]) |=>
      (lr_q == ONES && cmp_q == '0 && !flag_q && !cr_q[B_SWR]));
  // R5: write-one clears the flag
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !hit) |=> !flag_q);
  // R12: a compare hit raises the flag
  p_hit_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !sw_rst) |=> flag_q);
endmodule

// File: tb/test_cmptmr_top.sv
`timescale 1ns/1ps
module test_cmptmr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_main = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
  logic        irq;

  typedef struct {
    logic [31:0] expv;
    bit          is_irq;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmptmr_top i_cmptmr_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_main(tick_main),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq)
  );

  // monitor: compares queued expectations away from the rising edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      n_chk++;
      if (act !== it.expv) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.expv);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.expv = e; it.is_irq = 1'b0; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.expv = {31'b0, e}; it.is_irq = 1'b1; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  // which: 0 main, 1 fast, 2 slow
  task automatic tick(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tick_main = (which == 0); tick_fast = (which == 1); tick_slow = (which == 2);
      @(posedge clk); #1;
      tick_main = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8 reset values
    chk_rd(0, 32'h0, "R8 ctrl");
    chk_rd(1, 32'h0, "R8 status");
    chk_rd(2, 32'hFFFF_FFFF, "R8 load");
    chk_rd(3, 32'h0, "R8 compare");
    chk_rd(4, 32'hFFFF_FFFF, "R8 counter");
    chk_irq(1'b0, "R8 irq");
    // R1 map, read-only counter, unmapped
    wr(4, 32'h1234_5678);
    wr(6, 32'hAAAA_5555);
    chk_rd(4, 32'hFFFF_FFFF, "R1 counter read-only");
    chk_rd(5, 32'h0, "R1 unmapped read");
    chk_rd(7, 32'h0, "R1 unmapped read 7");
    chk_rd(3, 32'h0, "R1 compare untouched");
    // R6 mask
    wr(0, 32'hFFFE_FFFF);
    chk_rd(0, 32'h03FE_FFFF, "R6 ctrl mask");
    wr(0, 32'h0);
    // R10 enable with enable-mode and reload
    wr(2, 32'd10);
    wr(3, 32'd7);
    wr(0, 32'h0100_000F);
    chk_rd(4, 32'd10, "R10 enable load");
    tick(0, 1);
    chk_rd(4, 32'd9, "R9 decrement");
    chk_rd(1, 32'h0, "R12 no flag before match");
    tick(0, 2);
    chk_rd(1, 32'h1, "R12 flag on match");
    chk_irq(1'b1, "R4 irq high");
    // R5 write-zero then write-one
    wr(1, 32'h0);
    chk_rd(1, 32'h1, "R5 write zero no effect");
    wr(1, 32'h1);
    chk_rd(1, 32'h0, "R5 write one clears");
    chk_irq(1'b0, "R4 irq low after clear");
    // R9 reload at zero
    tick(0, 7);
    chk_rd(4, 32'd0, "R9 reached zero");
    tick(0, 1);
    chk_rd(4, 32'd10, "R9 reload");
    chk_rd(1, 32'h0, "R12 no flag on reload");
    // R12 masked interrupt still flags
    wr(0, 32'h0100_000B);
    tick(0, 3);
    chk_rd(1, 32'h1, "R12 flag while masked");
    chk_irq(1'b0, "R4 irq masked");
    wr(1, 32'h1);
    // R3 prescale 2
    wr(0, 32'h0100_002B);
    tick(0, 2);
    chk_rd(4, 32'd7, "R3 no step before divide");
    tick(0, 1);
    chk_rd(4, 32'd6, "R3 step on third tick");
    // R2 sources
    wr(0, 32'h0200_000B);
    tick(0, 2);
    chk_rd(4, 32'd6, "R2 main ignored on fast src");
    tick(1, 1);
    chk_rd(4, 32'd5, "R2 fast tick");
    wr(0, 32'h0300_000B);
    tick(1, 1);
    tick(2, 1);
    chk_rd(4, 32'd4, "R2 slow tick");
    wr(0, 32'h0000_000B);
    tick(0, 1); tick(1, 1); tick(2, 1);
    chk_rd(4, 32'd4, "R2 no source frozen");
    // R11 overwrite, R9 wrap
    wr(0, 32'h0102_0001);
    wr(2, 32'd1);
    chk_rd(4, 32'd1, "R11 overwrite load");
    tick(0, 1);
    chk_rd(4, 32'd0, "R9 down to zero");
    tick(0, 1);
    chk_rd(4, 32'hFFFF_FFFF, "R9 wrap to ones");
    // R13 disabled
    wr(0, 32'h0102_0000);
    tick(0, 2);
    chk_rd(4, 32'hFFFF_FFFF, "R13 disabled frozen");
    // R12 compare above limit
    wr(0, 32'h0102_0009);
    chk_rd(4, 32'hFFFF_FFFF, "R10 no load without enable-mode");
    wr(2, 32'd5);
    wr(3, 32'd9);
    wr(1, 32'h1);
    tick(0, 12);
    chk_rd(1, 32'h0, "R12 compare above limit");
    chk_rd(4, 32'd5, "R9 reload cycle count");
    // R7 soft reset
    wr(1, 32'h0);
    wr(0, 32'h013D_00FF);
    chk_rd(0, 32'h003C_0003, "R7 ctrl kept bits");
    chk_rd(1, 32'h0, "R7 status");
    chk_rd(2, 32'hFFFF_FFFF, "R7 load");
    chk_rd(3, 32'h0, "R7 compare");
    tick(0, 2);
    chk_rd(4, 32'd5, "R7 counter frozen");
    chk_irq(1'b0, "R7 irq low");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule